// File: doc/BRIEF.md
# Restoring Sequential Divider

This block divides one unsigned N-bit operand by another over several clock cycles, one quotient bit per cycle. A single `start` pulse captures both operands. A working remainder register of width 2N starts with the dividend zero-extended. A divisor register of width 2N starts with the divisor placed in its upper half and moves one bit to the right after every step.

Each step makes a trial subtraction of the divisor register from the remainder register and examines the borrow. When the trial goes below zero, the old remainder is kept, which restores it, and a 0 enters the quotient from the right. Otherwise the difference replaces the remainder and a 1 enters the quotient. After N+1 steps the quotient register holds the result. The low N bits of the remainder register hold the remainder.

The controller has three states:
- `ST_IDLE` waits for `start`. The transition *launch* (`start` high) loads the operands and moves to `ST_STEP`.
- `ST_STEP` performs one trial step per cycle. It stays in place (*iterate*) until step N+1. The transition *finish* then moves to `ST_DONE`.
- `ST_DONE` lasts one cycle and raises `done`. The transition *retire* returns to `ST_IDLE`.

Top module: `restoring_divider`

## Requirements
- R1: After reset, `busy`, `done`, `quotient` and `remainder` are all zero.
- R2: `start` sampled high in the idle state raises `busy` from the next cycle on.
- R3: `busy` stays high for exactly N+1 cycles. `done` is high in the cycle after the last step, that is N+1 rising edges after the edge that sampled `start`.
- R4: For a nonzero divisor, the outputs satisfy dividend = quotient × divisor + remainder with remainder < divisor.
- R5: 7 divided by 2 gives quotient 3 and remainder 1.
- R6: A zero divisor gives a quotient with every bit set and a remainder equal to the dividend. The operation still completes in the normal number of cycles.
- R7: `done` is a single-cycle pulse. `quotient` and `remainder` keep their values after it until the next accepted `start`.
- R8: `start` while `busy` is high is ignored. The running division finishes on its original operands and with its original timing.
- R9: A dividend smaller than the divisor gives quotient 0 and remainder equal to the dividend. The all-ones dividend divided by 1 gives the all-ones quotient and remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a division when idle |
| dividend | input | N | Unsigned dividend, sampled with start |
| divisor | input | N | Unsigned divisor, sampled with start |
| busy | output | 1 | High while steps are in progress |
| done | output | 1 | One-cycle pulse after the final step |
| quotient | output | N | Quotient, valid from done until next start |
| remainder | output | N | Remainder, valid from done until next start |

## Verification
The hardest condition to reach from the ports is a `start` that arrives in the middle of a division. If it were wrongly accepted, it would reload the operands partway through and corrupt the result. The bench launches a division and waits a few cycles. It then pulses `start` with different operands. Finally it checks that the original quotient and remainder come out, and that `done` arrives at the original cycle. The zero divisor is the other critical case, because every trial subtraction succeeds. The bench checks that this case ends normally and produces the all-ones quotient.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_DONE = 2'd2
    } rdiv_state_t;

endpackage

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
    import rdiv_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int STEPS = N + 1;
    localparam int CW    = $clog2(STEPS + 1);
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    rdiv_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin          // launch
                    state_d = ST_STEP;
                    cnt_d   = '0;
                end
            end
            ST_STEP: begin
                if (cnt_q == LAST) begin  // finish
                    state_d = ST_DONE;
                end else begin            // iterate
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_DONE: begin                // retire
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_STEP: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // R3: the step counter never passes the final step
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP) |-> (cnt_q <= LAST));

    // R7: done lasts one cycle only
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a running division is never abandoned back to idle
    a_r8_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/rdiv_datapath.sv
module rdiv_datapath #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [N-1:0] dividend,
    input  logic [N-1:0] divisor,
    output logic [N-1:0] quotient,
    output logic [N-1:0] remainder
);
    localparam int W = 2 * N;

    logic [W-1:0] rem_q;
    logic [W-1:0] dvs_q;
    logic [N-1:0] quo_q;
    logic [W:0]   trial;
    logic         below_zero;

    // trial subtraction with one extra bit to catch the borrow
    always_comb begin
        trial      = {1'b0, rem_q} - {1'b0, dvs_q};
        below_zero = trial[W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            dvs_q <= '0;
            quo_q <= '0;
        end else if (load) begin
            rem_q <= {{N{1'b0}}, dividend};
            dvs_q <= {divisor, {N{1'b0}}};
            quo_q <= '0;
        end else if (step) begin
            if (below_zero) begin
                rem_q <= rem_q;             // restore
                quo_q <= {quo_q[N-2:0], 1'b0};
            end else begin
                rem_q <= trial[W-1:0];
                quo_q <= {quo_q[N-2:0], 1'b1};
            end
            dvs_q <= dvs_q >> 1;
        end
    end

    assign quotient  = quo_q;
    assign remainder = rem_q[N-1:0];

    // R4: the working remainder never grows while stepping
    a_r4_rem_nonincreasing: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (rem_q <= $past(rem_q)));

    // R7: results are frozen when neither loading nor stepping
    a_r7_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(quo_q) && $stable(rem_q)));

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] dividend,
    input  logic [N-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] quotient,
    output logic [N-1:0] remainder
);
    logic load;
    logic step;

    rdiv_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    rdiv_datapath #(.N(N)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .dividend  (dividend),
        .divisor   (divisor),
        .quotient  (quotient),
        .remainder (remainder)
    );

    // R3: busy and done never overlap
    a_r3_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R2: an accepted start raises busy on the next cycle
    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);

endmodule

// File: tb/tb_restoring_divider.sv
module tb_restoring_divider;
    localparam int N      = 8;
    localparam int CLK_NS = 10;
    localparam logic [N-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] dividend = '0;
    logic [N-1:0] divisor = '0;
    logic         busy, done;
    logic [N-1:0] quotient, remainder;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    restoring_divider #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // launch a division, optionally disturb it with a second start, then check
    task automatic run_div(input string req, input logic [N-1:0] a, input logic [N-1:0] b,
                           input bit disturb);
        logic [N-1:0] eq, er;
        int cycles;
        if (b == 0) begin
            eq = ONES;
            er = a;
        end else begin
            eq = a / b;
            er = a % b;
        end
        @(negedge clk);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        cycles = 1;
        check({req, " R2 busy after start"}, busy, 1);
        while (!done && cycles < 100) begin
            if (disturb && cycles == 3) begin
                dividend = ~a;
                divisor  = b + 8'd3;
                start    = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cycles++;
            if (!done && cycles <= N + 1) check({req, " R3 busy during steps"}, busy, 1);
        end
        start = 1'b0;
        // done seen N+1 edges after the start edge: N+2 negedges counted from the drive
        check({req, " R3 done timing"}, cycles, N + 2);
        check({req, " R4 quotient"}, quotient, eq);
        check({req, " R4 remainder"}, remainder, er);
        @(negedge clk);
        check({req, " R7 done single pulse"}, done, 0);
        repeat (3) @(negedge clk);
        check({req, " R7 quotient held"}, quotient, eq);
        check({req, " R7 remainder held"}, remainder, er);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 quotient", quotient, 0);
        check("R1 remainder", remainder, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_sweep();
        logic [N-1:0] a = 8'd37;
        logic [N-1:0] b = 8'd11;
        for (int i = 0; i < 12; i++) begin
            a = a * 8'd29 + 8'd17;
            b = b * 8'd13 + 8'd5;
            if (i % 3 == 0) b = b >> 4;
            run_div("R4 sweep", a, b, 1'b0);
        end
    endtask

    initial begin
        t_reset();
        run_div("R5 seven by two", 8'd7, 8'd2, 1'b0);
        run_div("R4 hundred by seven", 8'd100, 8'd7, 1'b0);
        run_div("R6 divide by zero", 8'd201, 8'd0, 1'b0);
        run_div("R6 zero by zero", 8'd0, 8'd0, 1'b0);
        run_div("R9 small dividend", 8'd3, 8'd200, 1'b0);
        run_div("R9 max by one", ONES, 8'd1, 1'b0);
        run_div("R4 max by max", ONES, ONES, 1'b0);
        run_div("R8 start while busy", 8'd150, 8'd9, 1'b1);
        run_div("R8 start while busy zero div", 8'd77, 8'd0, 1'b1);
        t_sweep();
        finished = 1'b1;
    end

    initial begin
        int waited = 0;
        while (!finished && waited < 20000) begin
            @(posedge clk);
            waited++;
        end
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", waited, 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule